// File: doc/BRIEF.md
# IDE DMA Sector Progress Tracker

This block follows the progress of a scatter-gather DMA transfer between a descriptor-driven DMA engine and a block store. Software or a taskfile decoder first loads the starting position. In hard-disk mode that is a 512-byte sector address and a sector count. In packet (optical) mode it is a 2048-byte LBA, a byte offset inside that LBA and a remaining byte count. Each time the DMA engine presents a chunk descriptor (memory address and byte length), the tracker turns it into one request to the backing store. The request carries a 512-byte sector address, the memory address, the length and a read, write or trim kind.

When the store answers, the tracker advances the position by the bytes the finished chunk moved. A partial chunk is rounded up to whole sectors in disk mode. In packet mode the byte offset is folded into the LBA. The tracker raises completion when the count runs out and ends the DMA with a one-cycle pulse. An error answer aborts the transfer instead. Only one store request is ever in flight. A flush input is acknowledged once nothing is outstanding.

Top module: `ide_dma_progress`

## Requirements
- R1: After reset, busy, every pulse output (req_valid, irq, cmd_ok, dma_err, pkt_err, dma_end, flush_ack) and dev_status are zero.
- R2: The first step after xfer_start treats the previous chunk as zero bytes. The position does not move, so the first request's sector address equals the loaded position.
- R3: In disk mode a finished chunk of B bytes counts as n = (B + 511) >> 9 sectors. cur_sector grows by n and sect_left shrinks by n.
- R4: In disk mode, when sect_left becomes zero at a step, dev_status is set to 8'h50 (bit 6 ready, bit 4 seek complete) and irq pulses for one cycle.
- R5: In packet mode a finished chunk of B bytes is added to byte_index. cur_lba then grows by (byte_index >> 11) and byte_index keeps only its low 11 bits.
- R6: In packet mode pkt_left (signed) shrinks by B. When the result is zero or negative, cmd_ok pulses for one cycle.
- R7: In packet mode the request sector address is cur_lba*4 + (byte_index >> 9).
- R8: A descriptor of length zero ends the transfer with a dma_end pulse and no request. A non-zero descriptor gives exactly one request carrying its address and length. After the answer, dma_end pulses, and req_valid and dma_end never coincide.
- R9: req_kind is 0 for read, 1 for write and 2 for trim. Packet mode always uses read. req_to_dev is 1 for write and trim.
- R10: acct_bytes adds each launched chunk length for read, write and packet transfers, and is unchanged by trim. cfg_load clears it.
- R11: An error answer ends the transfer with dma_end together with dma_err (disk) or pkt_err (packet). Busy clears and the position is not advanced.
- R12: In disk mode byte_index is cleared when a chunk is launched.
- R13: At most one request is outstanding. Busy holds from issue until an answer, and xfer_start while a transfer runs is ignored.
- R14: flush_ack pulses one cycle after flush_req when idle. Otherwise it pulses one cycle after busy clears, and never while busy was set on the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load position and mode (taken only when idle) |
| cfg_pkt_mode | input | 1 | 1 = packet mode, 0 = disk mode |
| cfg_cmd | input | 2 | Disk command: 0 read, 1 write, 2 trim |
| cfg_sector | input | SECT_W | Disk start sector |
| cfg_count | input | CNT_W | Disk sector count |
| cfg_lba | input | LBA_W | Packet start LBA (2048-byte units) |
| cfg_index | input | IDX_W | Packet byte offset in LBA |
| cfg_pkt_bytes | input | PKT_W | Packet remaining byte count (signed) |
| xfer_start | input | 1 | Descriptor present, start a transfer |
| xfer_addr | input | ADDR_W | Descriptor memory address |
| xfer_len | input | LEN_W | Descriptor byte length |
| rsp_done | input | 1 | Store finished the request |
| rsp_err | input | 1 | Store failed the request |
| flush_req | input | 1 | Request flush acknowledgement |
| req_valid | output | 1 | One-cycle request pulse |
| req_kind | output | 2 | Request kind |
| req_to_dev | output | 1 | Data moves toward the device |
| req_sector | output | REQ_W | 512-byte sector address of request |
| req_mem_addr | output | ADDR_W | Memory address of request |
| req_len | output | LEN_W | Byte length of request |
| busy | output | 1 | A request is outstanding |
| cur_sector | output | SECT_W | Disk sector position |
| sect_left | output | CNT_W | Disk sectors left |
| cur_lba | output | LBA_W | Packet LBA position |
| byte_index | output | IDX_W | Byte offset inside LBA |
| pkt_left | output | PKT_W | Packet bytes left (signed) |
| dev_status | output | 8 | Drive status byte |
| irq | output | 1 | Disk completion interrupt pulse |
| cmd_ok | output | 1 | Packet completion pulse |
| dma_err | output | 1 | Disk DMA error pulse |
| pkt_err | output | 1 | Packet I/O error pulse |
| dma_end | output | 1 | End-of-DMA pulse |
| flush_ack | output | 1 | Flush acknowledge pulse |
| acct_bytes | output | ACCT_W | Accounted bytes since load |

## Verification
The assertions take for granted that the store answers only while a request is outstanding, with at most one of rsp_done and rsp_err per cycle. They also assume cfg_load is only pulsed while the tracker is idle. The stimulus answers each request a few cycles after seeing req_valid, raising exactly one of the two answers for a single cycle. It loads the position only between transfers. The stray xfer_start and flush_req pulses it drives mid-transfer are ones the design must tolerate by rule.

// File: rtl/ide_dma_pkg.sv
package ide_dma_pkg;
  typedef enum logic [1:0] {
    CMD_READ  = 2'd0,
    CMD_WRITE = 2'd1,
    CMD_TRIM  = 2'd2
  } dma_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_STEP = 2'd1,
    ST_WAIT = 2'd2
  } trk_state_e;

  localparam logic [7:0] STAT_READY_SEEK = 8'h50;
endpackage

// File: rtl/ide_disk_pos.sv
module ide_disk_pos #(
  parameter int SECT_W = 28,
  parameter int CNT_W  = 16,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [SECT_W-1:0] ld_sector,
  input  logic [CNT_W-1:0]  ld_count,
  input  logic              step,
  input  logic [LEN_W-1:0]  chunk,
  output logic [SECT_W-1:0] sector,
  output logic [CNT_W-1:0]  count,
  output logic [SECT_W-1:0] sector_nx,
  output logic              done_nx
);
  localparam int SUM_W = LEN_W + 1;
  localparam int N_W   = SUM_W - 9;

  logic [SUM_W-1:0] rounded;
  logic [N_W-1:0]   nsec;
  logic [CNT_W-1:0] count_nx;

  // round a partial chunk up to whole 512-byte sectors
  always_comb begin
    rounded   = SUM_W'(chunk) + SUM_W'(511);
    nsec      = rounded[SUM_W-1:9];
    sector_nx = sector + SECT_W'(nsec);
    count_nx  = count - CNT_W'(nsec);
    done_nx   = (count_nx == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sector <= '0;
      count  <= '0;
    end else if (load) begin
      sector <= ld_sector;
      count  <= ld_count;
    end else if (step) begin
      sector <= sector_nx;
      count  <= count_nx;
    end
  end
endmodule

// File: rtl/ide_pkt_pos.sv
module ide_pkt_pos #(
  parameter int LBA_W = 26,
  parameter int IDX_W = 11,
  parameter int LEN_W = 16,
  parameter int PKT_W = 24
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic [LBA_W-1:0]        ld_lba,
  input  logic [IDX_W-1:0]        ld_idx,
  input  logic signed [PKT_W-1:0] ld_left,
  input  logic                    step,
  input  logic                    clr_idx,
  input  logic [LEN_W-1:0]        chunk,
  output logic [LBA_W-1:0]        lba,
  output logic [IDX_W-1:0]        idx,
  output logic signed [PKT_W-1:0] left,
  output logic [LBA_W-1:0]        lba_nx,
  output logic [IDX_W-1:0]        idx_nx,
  output logic                    ok_nx
);
  localparam int SUM_W = LEN_W + 1;

  logic [SUM_W-1:0]        sum;
  logic signed [PKT_W-1:0] left_nx;

  // fold whole 2048-byte blocks of the offset into the LBA
  always_comb begin
    sum     = SUM_W'(idx) + SUM_W'(chunk);
    lba_nx  = lba + LBA_W'(sum >> IDX_W);
    idx_nx  = sum[IDX_W-1:0];
    left_nx = left - $signed(PKT_W'(chunk));
    ok_nx   = (left_nx <= 0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lba  <= '0;
      idx  <= '0;
      left <= '0;
    end else if (load) begin
      lba  <= ld_lba;
      idx  <= ld_idx;
      left <= ld_left;
    end else begin
      if (step) begin
        lba  <= lba_nx;
        idx  <= idx_nx;
        left <= left_nx;
      end
      if (clr_idx) idx <= '0;
    end
  end
endmodule

// File: rtl/ide_dma_ctrl.sv
module ide_dma_ctrl
  import ide_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int REQ_W  = 28,
  parameter int ACCT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_load,
  input  logic              cfg_pkt_mode,
  input  logic [1:0]        cfg_cmd,
  input  logic              xfer_start,
  input  logic [ADDR_W-1:0] xfer_addr,
  input  logic [LEN_W-1:0]  xfer_len,
  input  logic              rsp_done,
  input  logic              rsp_err,
  input  logic              flush_req,
  input  logic              disk_done_nx,
  input  logic              pkt_ok_nx,
  input  logic [REQ_W-1:0]  req_addr_nx,
  output logic              pkt_mode,
  output logic              load_ok,
  output logic              step,
  output logic              launch,
  output logic [LEN_W-1:0]  chunk,
  output logic              req_valid,
  output logic [1:0]        req_kind,
  output logic              req_to_dev,
  output logic [REQ_W-1:0]  req_sector,
  output logic [ADDR_W-1:0] req_mem_addr,
  output logic [LEN_W-1:0]  req_len,
  output logic              busy,
  output logic [7:0]        dev_status,
  output logic              irq,
  output logic              cmd_ok,
  output logic              dma_err,
  output logic              pkt_err,
  output logic              dma_end,
  output logic              flush_ack,
  output logic [ACCT_W-1:0] acct_bytes
);
  trk_state_e        state;
  dma_cmd_e          cmd;
  logic [ADDR_W-1:0] io_addr;
  logic [LEN_W-1:0]  io_len;
  logic              flush_pend;
  logic              count_acct;

  assign load_ok    = cfg_load && (state == ST_IDLE);
  assign step       = (state == ST_STEP);
  assign launch     = step && (io_len != '0);
  assign count_acct = pkt_mode || (cmd == CMD_READ) || (cmd == CMD_WRITE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      cmd          <= CMD_READ;
      pkt_mode     <= 1'b0;
      io_addr      <= '0;
      io_len       <= '0;
      chunk        <= '0;
      req_valid    <= 1'b0;
      req_kind     <= 2'd0;
      req_to_dev   <= 1'b0;
      req_sector   <= '0;
      req_mem_addr <= '0;
      req_len      <= '0;
      busy         <= 1'b0;
      dev_status   <= 8'h00;
      irq          <= 1'b0;
      cmd_ok       <= 1'b0;
      dma_err      <= 1'b0;
      pkt_err      <= 1'b0;
      dma_end      <= 1'b0;
      flush_ack    <= 1'b0;
      flush_pend   <= 1'b0;
      acct_bytes   <= '0;
    end else begin
      req_valid <= 1'b0;
      irq       <= 1'b0;
      cmd_ok    <= 1'b0;
      dma_err   <= 1'b0;
      pkt_err   <= 1'b0;
      dma_end   <= 1'b0;
      flush_ack <= 1'b0;

      if ((flush_req || flush_pend) && !busy) begin
        flush_ack  <= 1'b1;
        flush_pend <= 1'b0;
      end else if (flush_req) begin
        flush_pend <= 1'b1;
      end

      if (load_ok) begin
        pkt_mode   <= cfg_pkt_mode;
        cmd        <= dma_cmd_e'(cfg_cmd);
        dev_status <= 8'h00;
        acct_bytes <= '0;
      end

      case (state)
        ST_IDLE: begin
          if (xfer_start) begin
            io_addr <= xfer_addr;
            io_len  <= xfer_len;
            chunk   <= '0;
            state   <= ST_STEP;
          end
        end
        ST_STEP: begin
          if (!pkt_mode && disk_done_nx) begin
            dev_status <= STAT_READY_SEEK;
            irq        <= 1'b1;
          end
          if (pkt_mode && pkt_ok_nx) cmd_ok <= 1'b1;
          if (io_len == '0) begin
            dma_end <= 1'b1;
            state   <= ST_IDLE;
          end else begin
            req_valid    <= 1'b1;
            req_kind     <= pkt_mode ? 2'(CMD_READ) : 2'(cmd);
            req_to_dev   <= !pkt_mode && (cmd != CMD_READ);
            req_sector   <= req_addr_nx;
            req_mem_addr <= io_addr;
            req_len      <= io_len;
            io_addr      <= io_addr + ADDR_W'(io_len);
            io_len       <= '0;
            chunk        <= io_len;
            busy         <= 1'b1;
            if (count_acct) acct_bytes <= acct_bytes + ACCT_W'(io_len);
            state        <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (rsp_err) begin
            busy    <= 1'b0;
            dma_end <= 1'b1;
            chunk   <= '0;
            if (pkt_mode) pkt_err <= 1'b1;
            else          dma_err <= 1'b1;
            state   <= ST_IDLE;
          end else if (rsp_done) begin
            busy  <= 1'b0;
            state <= ST_STEP;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ide_dma_progress.sv
module ide_dma_progress #(
  parameter int SECT_W = 28,
  parameter int CNT_W  = 16,
  parameter int LBA_W  = 26,
  parameter int IDX_W  = 11,
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 32,
  parameter int PKT_W  = 24,
  parameter int ACCT_W = 32,
  localparam int REQ_W = (LBA_W + 2 > SECT_W) ? LBA_W + 2 : SECT_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_load,
  input  logic                    cfg_pkt_mode,
  input  logic [1:0]              cfg_cmd,
  input  logic [SECT_W-1:0]       cfg_sector,
  input  logic [CNT_W-1:0]        cfg_count,
  input  logic [LBA_W-1:0]        cfg_lba,
  input  logic [IDX_W-1:0]        cfg_index,
  input  logic signed [PKT_W-1:0] cfg_pkt_bytes,
  input  logic                    xfer_start,
  input  logic [ADDR_W-1:0]       xfer_addr,
  input  logic [LEN_W-1:0]        xfer_len,
  input  logic                    rsp_done,
  input  logic                    rsp_err,
  input  logic                    flush_req,
  output logic                    req_valid,
  output logic [1:0]              req_kind,
  output logic                    req_to_dev,
  output logic [REQ_W-1:0]        req_sector,
  output logic [ADDR_W-1:0]       req_mem_addr,
  output logic [LEN_W-1:0]        req_len,
  output logic                    busy,
  output logic [SECT_W-1:0]       cur_sector,
  output logic [CNT_W-1:0]        sect_left,
  output logic [LBA_W-1:0]        cur_lba,
  output logic [IDX_W-1:0]        byte_index,
  output logic signed [PKT_W-1:0] pkt_left,
  output logic [7:0]              dev_status,
  output logic                    irq,
  output logic                    cmd_ok,
  output logic                    dma_err,
  output logic                    pkt_err,
  output logic                    dma_end,
  output logic                    flush_ack,
  output logic [ACCT_W-1:0]       acct_bytes
);
  logic              pkt_mode, load_ok, step, launch;
  logic [LEN_W-1:0]  chunk;
  logic [SECT_W-1:0] sector_nx;
  logic              disk_done_nx;
  logic [LBA_W-1:0]  lba_nx;
  logic [IDX_W-1:0]  idx_nx;
  logic              pkt_ok_nx;
  logic [REQ_W-1:0]  req_addr_nx;

  // packet requests address 512-byte units: LBA*4 plus quarter-block offset
  always_comb begin
    if (pkt_mode) req_addr_nx = REQ_W'({lba_nx, 2'b00}) + REQ_W'(idx_nx >> 9);
    else          req_addr_nx = REQ_W'(sector_nx);
  end

  ide_disk_pos #(.SECT_W(SECT_W), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_disk (
    .clk(clk), .rst(rst), .load(load_ok),
    .ld_sector(cfg_sector), .ld_count(cfg_count),
    .step(step && !pkt_mode), .chunk(chunk),
    .sector(cur_sector), .count(sect_left),
    .sector_nx(sector_nx), .done_nx(disk_done_nx)
  );

  ide_pkt_pos #(.LBA_W(LBA_W), .IDX_W(IDX_W), .LEN_W(LEN_W), .PKT_W(PKT_W)) u_pkt (
    .clk(clk), .rst(rst), .load(load_ok),
    .ld_lba(cfg_lba), .ld_idx(cfg_index), .ld_left(cfg_pkt_bytes),
    .step(step && pkt_mode), .clr_idx(launch && !pkt_mode), .chunk(chunk),
    .lba(cur_lba), .idx(byte_index), .left(pkt_left),
    .lba_nx(lba_nx), .idx_nx(idx_nx), .ok_nx(pkt_ok_nx)
  );

  ide_dma_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .REQ_W(REQ_W), .ACCT_W(ACCT_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .cfg_load(cfg_load), .cfg_pkt_mode(cfg_pkt_mode), .cfg_cmd(cfg_cmd),
    .xfer_start(xfer_start), .xfer_addr(xfer_addr), .xfer_len(xfer_len),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .flush_req(flush_req),
    .disk_done_nx(disk_done_nx), .pkt_ok_nx(pkt_ok_nx), .req_addr_nx(req_addr_nx),
    .pkt_mode(pkt_mode), .load_ok(load_ok), .step(step), .launch(launch), .chunk(chunk),
    .req_valid(req_valid), .req_kind(req_kind), .req_to_dev(req_to_dev),
    .req_sector(req_sector), .req_mem_addr(req_mem_addr), .req_len(req_len),
    .busy(busy), .dev_status(dev_status), .irq(irq), .cmd_ok(cmd_ok),
    .dma_err(dma_err), .pkt_err(pkt_err), .dma_end(dma_end),
    .flush_ack(flush_ack), .acct_bytes(acct_bytes)
  );
endmodule

// File: rtl/ide_dma_progress_chk.sv
module ide_dma_progress_chk #(
  parameter int PKT_W = 24,
  parameter int LEN_W = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    req_valid,
  input logic [LEN_W-1:0]        req_len,
  input logic                    busy,
  input logic                    rsp_done,
  input logic                    rsp_err,
  input logic                    dma_end,
  input logic                    dma_err,
  input logic                    pkt_err,
  input logic                    irq,
  input logic [7:0]              dev_status,
  input logic                    cmd_ok,
  input logic signed [PKT_W-1:0] pkt_left,
  input logic                    flush_ack
);
  a_r13_one_outstanding: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> !$past(busy));

  a_r13_busy_holds: assert property (@(posedge clk) disable iff (rst)
    (busy && !rsp_done && !rsp_err) |=> busy);

  a_r8_end_not_with_req: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && dma_end));

  a_r8_req_nonempty: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_len != '0));

  a_r11_error_ends: assert property (@(posedge clk) disable iff (rst)
    (dma_err || pkt_err) |-> (dma_end && !busy));

  a_r4_irq_status: assert property (@(posedge clk) disable iff (rst)
    irq |-> (dev_status == 8'h50));

  a_r6_ok_exhausted: assert property (@(posedge clk) disable iff (rst)
    cmd_ok |-> (pkt_left <= 0));

  a_r14_flush_idle: assert property (@(posedge clk) disable iff (rst)
    flush_ack |-> !$past(busy));
endmodule

bind ide_dma_progress ide_dma_progress_chk #(.PKT_W(PKT_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_len(req_len), .busy(busy),
  .rsp_done(rsp_done), .rsp_err(rsp_err), .dma_end(dma_end), .dma_err(dma_err),
  .pkt_err(pkt_err), .irq(irq), .dev_status(dev_status), .cmd_ok(cmd_ok),
  .pkt_left(pkt_left), .flush_ack(flush_ack)
);

// File: tb/ide_dma_progress_test.sv
module ide_dma_progress_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        cfg_load = 0, cfg_pkt_mode = 0;
  logic [1:0]  cfg_cmd = 0;
  logic [27:0] cfg_sector = 0;
  logic [15:0] cfg_count = 0;
  logic [25:0] cfg_lba = 0;
  logic [10:0] cfg_index = 0;
  logic signed [23:0] cfg_pkt_bytes = 0;
  logic        xfer_start = 0;
  logic [31:0] xfer_addr = 0;
  logic [15:0] xfer_len = 0;
  logic        rsp_done = 0, rsp_err = 0, flush_req = 0;

  logic        req_valid, req_to_dev, busy, irq, cmd_ok, dma_err, pkt_err, dma_end, flush_ack;
  logic [1:0]  req_kind;
  logic [27:0] req_sector, cur_sector;
  logic [31:0] req_mem_addr, acct_bytes;
  logic [15:0] req_len, sect_left;
  logic [25:0] cur_lba;
  logic [10:0] byte_index;
  logic signed [23:0] pkt_left;
  logic [7:0]  dev_status;

  ide_dma_progress uut (.*);

  int checks = 0, errors = 0;

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // captured per transfer
  int n_req, rsp_idx, ack_idx;
  bit saw_irq, saw_ok, saw_derr, saw_perr, saw_end, busy_after;
  longint r_sector, r_maddr, r_len, r_kind, r_todev, idx_at_req;

  task automatic cfg(input bit pkt, input [1:0] cmd, input [27:0] sec, input [15:0] cnt,
                     input [25:0] lba, input [10:0] idx, input int left);
    @(negedge clk);
    cfg_load = 1; cfg_pkt_mode = pkt; cfg_cmd = cmd; cfg_sector = sec; cfg_count = cnt;
    cfg_lba = lba; cfg_index = idx; cfg_pkt_bytes = 24'(left);
    @(negedge clk);
    cfg_load = 0;
  endtask

  task automatic xfer(input [31:0] addr, input [15:0] len, input bit err,
                      input bit flush_mid, input bit restart_mid);
    int wait_rsp = -1;
    n_req = 0; rsp_idx = -1; ack_idx = -1;
    saw_irq = 0; saw_ok = 0; saw_derr = 0; saw_perr = 0; saw_end = 0;
    idx_at_req = -1;
    @(negedge clk);
    xfer_start = 1; xfer_addr = addr; xfer_len = len;
    for (int i = 0; i < 40 && !saw_end; i++) begin
      @(negedge clk);
      xfer_start = 0; rsp_done = 0; rsp_err = 0; flush_req = 0;
      if (irq) saw_irq = 1;
      if (cmd_ok) saw_ok = 1;
      if (dma_err) saw_derr = 1;
      if (pkt_err) saw_perr = 1;
      if (flush_ack && ack_idx < 0) ack_idx = i;
      if (dma_end) saw_end = 1;
      if (req_valid) begin
        n_req++;
        r_sector = req_sector; r_maddr = req_mem_addr; r_len = req_len;
        r_kind = req_kind; r_todev = req_to_dev; idx_at_req = byte_index;
        wait_rsp = 3;
        if (flush_mid) flush_req = 1;
        if (restart_mid) begin xfer_start = 1; xfer_len = 16'd512; end
      end else if (wait_rsp > 0) begin
        wait_rsp--;
        if (wait_rsp == 0) begin
          rsp_idx = i;
          if (err) rsp_err = 1; else rsp_done = 1;
        end
      end
    end
    busy_after = busy;
    repeat (4) begin
      @(negedge clk);
      if (req_valid) n_req++;
    end
  endtask

  // disk chunk vectors: {length, expected sector advance}
  localparam logic [31:0] DISK_VEC [6] = '{
    {16'd1,    16'd1}, {16'd511,  16'd1}, {16'd512, 16'd1},
    {16'd513,  16'd2}, {16'd4096, 16'd8}, {16'd1000, 16'd2}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 dev_status", dev_status, 0);
    check("R1 pulses", {req_valid, irq, cmd_ok, dma_err, pkt_err, dma_end, flush_ack}, 0);

    // R2 R3 R8 R10: disk read vectors
    foreach (DISK_VEC[k]) begin
      cfg(0, 2'd0, 28'd1000, 16'd20, 0, 0, 0);
      xfer(32'h1000_0000 + 32'(k) * 32'h100, DISK_VEC[k][31:16], 0, 0, 0);
      check("R2 entry sector", r_sector, 1000);
      check("R8 one request", n_req, 1);
      check("R8 mem addr", r_maddr, 32'h1000_0000 + k * 32'h100);
      check("R8 req len", r_len, DISK_VEC[k][31:16]);
      check("R8 end", saw_end, 1);
      check("R3 sector", cur_sector, 1000 + DISK_VEC[k][15:0]);
      check("R3 left", sect_left, 20 - DISK_VEC[k][15:0]);
      check("R4 no irq", saw_irq, 0);
      check("R9 read kind", r_kind, 0);
      check("R10 acct", acct_bytes, DISK_VEC[k][31:16]);
    end

    // R4 R9 disk write completes count
    cfg(0, 2'd1, 28'd200, 16'd2, 0, 0, 0);
    xfer(32'h2000, 16'd700, 0, 0, 0);
    check("R9 write kind", r_kind, 1);
    check("R9 write to dev", r_todev, 1);
    check("R4 irq", saw_irq, 1);
    check("R4 status", dev_status, 8'h50);
    check("R3 done left", sect_left, 0);
    check("R3 done sector", cur_sector, 202);

    // R9 R10 R12 trim
    cfg(0, 2'd2, 28'd300, 16'd8, 0, 11'd5, 0);
    xfer(32'h3000, 16'd1536, 0, 0, 0);
    check("R9 trim kind", r_kind, 2);
    check("R9 trim to dev", r_todev, 1);
    check("R10 trim no acct", acct_bytes, 0);
    check("R12 index cleared", idx_at_req, 0);
    check("R3 trim sector", cur_sector, 303);

    // R5 R6 R7 packet
    cfg(1, 2'd1, 0, 0, 26'd100, 11'h600, 3000);
    xfer(32'h4000, 16'd1000, 0, 0, 0);
    check("R7 req addr", r_sector, 403);
    check("R9 pkt read", r_kind, 0);
    check("R5 lba", cur_lba, 101);
    check("R5 index", byte_index, 488);
    check("R6 left", pkt_left, 2000);
    check("R6 no ok", saw_ok, 0);
    xfer(32'h5000, 16'd2048, 0, 0, 0);
    check("R7 req addr 2", r_sector, 404);
    check("R5 lba 2", cur_lba, 102);
    check("R5 index 2", byte_index, 488);
    check("R6 left neg", pkt_left, -48);
    check("R6 ok", saw_ok, 1);
    check("R10 pkt acct", acct_bytes, 3048);

    // R8 zero length
    cfg(0, 2'd0, 28'd10, 16'd3, 0, 0, 0);
    xfer(32'h6000, 16'd0, 0, 0, 0);
    check("R8 no req", n_req, 0);
    check("R8 zero end", saw_end, 1);
    check("R2 zero sector", cur_sector, 10);

    // R11 disk error
    cfg(0, 2'd0, 28'd50, 16'd4, 0, 0, 0);
    xfer(32'h7000, 16'd1024, 1, 0, 0);
    check("R11 dma_err", saw_derr, 1);
    check("R11 no pkt_err", saw_perr, 0);
    check("R11 end", saw_end, 1);
    check("R11 busy", busy_after, 0);
    check("R11 sector kept", cur_sector, 50);
    check("R11 left kept", sect_left, 4);

    // R11 packet error
    cfg(1, 2'd0, 0, 0, 26'd7, 0, 100);
    xfer(32'h8000, 16'd512, 1, 0, 0);
    check("R11 pkt_err", saw_perr, 1);
    check("R11 lba kept", cur_lba, 7);
    check("R11 pkt left kept", pkt_left, 100);

    // R13 restart while busy ignored
    cfg(0, 2'd0, 28'd40, 16'd10, 0, 0, 0);
    xfer(32'h9000, 16'd1024, 0, 0, 1);
    check("R13 single req", n_req, 1);
    check("R13 sector", cur_sector, 42);
    check("R13 acct", acct_bytes, 1024);

    // R14 flush while busy
    cfg(0, 2'd0, 28'd60, 16'd10, 0, 0, 0);
    xfer(32'hA000, 16'd512, 0, 1, 0);
    check("R14 ack after busy", ack_idx, rsp_idx + 2);

    // R14 flush when idle
    @(negedge clk); flush_req = 1;
    @(negedge clk); flush_req = 0;
    check("R14 idle ack", flush_ack, 1);
    @(negedge clk);
    check("R14 single pulse", flush_ack, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule